// File: doc/BRIEF.md
# Manchester Word Encoder with Synchronizing Character

The block turns one data word into a self-clocking serial frame for a two-wire bipolar line driver. It runs from an encoder clock at twice the bit rate, so every clock cycle is one half-cell on the line. A frame opens with a synchronizing character three bit times long. That character breaks the Manchester rule on purpose, so a receiver can find the start of the word. The word bits follow, most significant first, each as a two-half-cell Manchester symbol. An odd-parity bit closes the frame.

The block does not take a parallel word. It produces its own shift clock and samples the serial input on each rising edge of that clock, one bit per data cell. The sync-select input picks a command-type or a data-type character and is captured when the frame starts. A new frame begins only at a frame boundary with the enable input high. If enable is still high on the last half-cell, frames run back to back with no gap. The line outputs are active low, one per sense. An active-low inhibit input parks both outputs at their inactive level at once. A free-running divide-by-6 of the encoder clock is also provided.

Top module: `manch_word_enc`

## Requirements
- R1: While master reset is high, both line outputs are high, the shift clock is low, the divided clock is low and any frame in progress is dropped.
- R2: After reset is released the divided clock is low for 3 encoder clocks, then high for 3, with a period of 6 clocks.
- R3: Enable is looked at only when no frame is running or on the last half-cell of a frame. The first half-cell of a frame appears on the edge where enable is seen high. With no frame running, both line outputs stay high and enable changes inside a frame have no effect.
- R4: The synchronizing character is 6 half-cells long. For command type (sync-select 1 when the frame starts) it is positive for 3 half-cells and then negative for 3. For data type (sync-select 0) it is negative for 3 and then positive for 3. Sync-select changes after the start have no effect.
- R5: The 16 word bits follow the character, first-sampled bit first. A one is positive then negative, and a zero is negative then positive.
- R6: The shift clock is high only during the first half-cell of each of the 16 data cells. The serial input present at its rising edge is the bit sent in that cell, and the serial input is ignored at every other time.
- R7: The last cell carries a parity bit chosen so that the 16 word bits and the parity bit hold an odd number of ones. It is coded like a data bit, which makes a frame 40 half-cells long.
- R8: Positive line level is shown as positive output 0 and negative output 1, and negative level as the reverse.
- R9: While inhibit is low, both line outputs are high in the same cycle. The frame sequence keeps running underneath.
- R10: If enable is high on the last half-cell, the next frame's first half-cell follows on the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_clk | input | 1 | Encoder clock, twice the bit rate |
| mreset | input | 1 | Master reset, active high, asynchronous |
| sync_sel | input | 1 | Character type at frame start: 1 command, 0 data |
| enc_en | input | 1 | Start or continue framing at a frame boundary |
| ser_in | input | 1 | Serial word data, sampled on the shift clock rising edge |
| line_inhibit_n | input | 1 | Low forces both line outputs inactive |
| shift_clk | output | 1 | Shift clock for the serial source, one pulse per data cell |
| pos_n | output | 1 | Positive-sense line drive, active low |
| neg_n | output | 1 | Negative-sense line drive, active low |
| div6_clk | output | 1 | Encoder clock divided by 6 |

## Verification
Frames are sent with all-zero and all-one words, the two alternating patterns, and walking-one and walking-zero words. This separates bit order, the half-cell order inside a symbol and parity of both polarities. Pseudo-random words cover general cases. Command and data characters alternate. Frames run both back to back and with idle gaps between them, which tells the boundary-only sampling of enable apart from level sensing. Noise on the serial input outside shift-clock edges, toggling of enable and sync-select inside a frame, one inhibited half-cell per frame and a reset in the middle of a frame show which inputs the line actually follows and when.

// File: rtl/manch_enc_pkg.sv
package manch_enc_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_DATA = 2'd1,
    SEG_PAR  = 2'd2
  } seg_e;

  // Which part of the frame a half-cell index falls in.
  function automatic seg_e seg_of(input int unsigned h,
                                  input int unsigned sync_halves,
                                  input int unsigned data_bits);
    if (h < 2 * sync_halves) return SEG_SYNC;
    if (h < 2 * sync_halves + 2 * data_bits) return SEG_DATA;
    return SEG_PAR;
  endfunction

  // Line level (1 = positive) during the synchronizing character.
  function automatic logic sync_level(input int unsigned h,
                                      input int unsigned sync_halves,
                                      input logic cmd);
    logic early;
    early = (h < sync_halves);
    return cmd ? early : ~early;
  endfunction

  // Manchester symbol: the bit value, then its complement.
  function automatic logic cell_level(input logic bit_val, input logic second_half);
    return bit_val ^ second_half;
  endfunction

  // Parity bit that makes the total count of ones odd.
  function automatic logic odd_fill(input logic xor_acc);
    return ~xor_acc;
  endfunction

endpackage

// File: rtl/manch_enc_div.sv
module manch_enc_div #(
  parameter int unsigned DIV = 6
) (
  input  logic clk,
  input  logic rst,
  output logic div_clk
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;
  logic          half;

  assign wrap = (cnt_q == CW'(DIV - 1));
  assign half = (cnt_q == CW'(DIV / 2 - 1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q   <= '0;
      div_clk <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + CW'(1);
      if (wrap || half) div_clk <= ~div_clk;
    end
  end
endmodule

// File: rtl/manch_enc_seq.sv
module manch_enc_seq #(
  parameter int unsigned HALVES = 40,
  parameter int unsigned HW     = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enc_en,
  input  logic          sync_sel,
  output logic          active_q,
  output logic [HW-1:0] hc_q,
  output logic          cmd_q,
  output logic          nxt_active,
  output logic [HW-1:0] nxt_hc,
  output logic          nxt_cmd,
  output logic          frame_start
);
  logic boundary;

  assign boundary    = !active_q || (hc_q == HW'(HALVES - 1));
  assign frame_start = boundary && enc_en;

  always_comb begin
    nxt_active = boundary ? enc_en : 1'b1;
    nxt_hc     = boundary ? '0 : hc_q + HW'(1);
    nxt_cmd    = boundary ? sync_sel : cmd_q;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      active_q <= 1'b0;
      hc_q     <= '0;
      cmd_q    <= 1'b0;
    end else begin
      active_q <= nxt_active;
      hc_q     <= nxt_hc;
      cmd_q    <= nxt_cmd;
    end
  end
endmodule

// File: rtl/manch_enc_shape.sv
module manch_enc_shape
  import manch_enc_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 16,
  parameter int unsigned SYNC_HALVES = 3,
  parameter int unsigned HW          = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nxt_active,
  input  logic [HW-1:0] nxt_hc,
  input  logic          nxt_cmd,
  input  logic          frame_start,
  input  logic          ser_in,
  output logic          pos_q,
  output logic          neg_q,
  output logic          shift_q,
  output logic          take_bit
);
  seg_e nseg;
  logic second;
  logic lvl;
  logic bit_q;
  logic acc_q;

  assign nseg     = seg_of(32'(nxt_hc), SYNC_HALVES, DATA_BITS);
  assign second   = nxt_hc[0];
  assign take_bit = nxt_active && (nseg == SEG_DATA) && !second;

  always_comb begin
    case (nseg)
      SEG_SYNC: lvl = sync_level(32'(nxt_hc), SYNC_HALVES, nxt_cmd);
      SEG_DATA: lvl = second ? cell_level(bit_q, 1'b1) : cell_level(ser_in, 1'b0);
      default:  lvl = cell_level(odd_fill(acc_q), second);
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pos_q   <= 1'b0;
      neg_q   <= 1'b0;
      shift_q <= 1'b0;
      bit_q   <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      pos_q   <= nxt_active & lvl;
      neg_q   <= nxt_active & ~lvl;
      shift_q <= take_bit;
      if (take_bit) bit_q <= ser_in;
      if (frame_start) acc_q <= 1'b0;
      else if (take_bit) acc_q <= acc_q ^ ser_in;
    end
  end
endmodule

// File: rtl/manch_word_enc.sv
module manch_word_enc #(
  parameter int unsigned DATA_BITS   = 16,
  parameter int unsigned SYNC_HALVES = 3,
  parameter int unsigned DIV_RATIO   = 6
) (
  input  logic enc_clk,
  input  logic mreset,
  input  logic sync_sel,
  input  logic enc_en,
  input  logic ser_in,
  input  logic line_inhibit_n,
  output logic shift_clk,
  output logic pos_n,
  output logic neg_n,
  output logic div6_clk
);
  localparam int unsigned HALVES = 2 * SYNC_HALVES + 2 * DATA_BITS + 2;
  localparam int unsigned HW     = $clog2(HALVES);

  logic          active_q;
  logic [HW-1:0] hc_q;
  logic          cmd_q;
  logic          nxt_active;
  logic [HW-1:0] nxt_hc;
  logic          nxt_cmd;
  logic          frame_start;
  logic          pos_q;
  logic          neg_q;
  logic          take_bit;

  manch_enc_seq #(.HALVES(HALVES), .HW(HW)) u_seq (
    .clk(enc_clk), .rst(mreset), .enc_en(enc_en), .sync_sel(sync_sel),
    .active_q(active_q), .hc_q(hc_q), .cmd_q(cmd_q),
    .nxt_active(nxt_active), .nxt_hc(nxt_hc), .nxt_cmd(nxt_cmd),
    .frame_start(frame_start)
  );

  manch_enc_shape #(.DATA_BITS(DATA_BITS), .SYNC_HALVES(SYNC_HALVES), .HW(HW)) u_shape (
    .clk(enc_clk), .rst(mreset), .nxt_active(nxt_active), .nxt_hc(nxt_hc),
    .nxt_cmd(nxt_cmd), .frame_start(frame_start), .ser_in(ser_in),
    .pos_q(pos_q), .neg_q(neg_q), .shift_q(shift_clk), .take_bit(take_bit)
  );

  manch_enc_div #(.DIV(DIV_RATIO)) u_div (
    .clk(enc_clk), .rst(mreset), .div_clk(div6_clk)
  );

  assign pos_n = ~(pos_q & line_inhibit_n);
  assign neg_n = ~(neg_q & line_inhibit_n);
endmodule

// File: rtl/manch_word_enc_chk.sv
module manch_word_enc_chk #(
  parameter int unsigned DATA_BITS   = 16,
  parameter int unsigned SYNC_HALVES = 3,
  parameter int unsigned HW          = 6
) (
  input logic          enc_clk,
  input logic          mreset,
  input logic          line_inhibit_n,
  input logic          shift_clk,
  input logic          pos_n,
  input logic          neg_n,
  input logic          div6_clk,
  input logic          active_q,
  input logic [HW-1:0] hc_q,
  input logic          pos_q
);
  localparam int unsigned HALVES = 2 * SYNC_HALVES + 2 * DATA_BITS + 2;
  localparam int unsigned D0     = 2 * SYNC_HALVES;
  localparam int unsigned D1     = D0 + 2 * DATA_BITS;

  AST_INHIBIT_QUIET: assert property (@(posedge enc_clk) disable iff (mreset)
    !line_inhibit_n |-> (pos_n && neg_n)); // R9
  AST_IDLE_QUIET: assert property (@(posedge enc_clk) disable iff (mreset)
    !active_q |-> (pos_n && neg_n && !shift_clk)); // R3
  AST_ACTIVE_DRIVES: assert property (@(posedge enc_clk) disable iff (mreset)
    (active_q && line_inhibit_n) |-> (pos_n != neg_n)); // R8
  AST_SHIFT_IN_DATA: assert property (@(posedge enc_clk) disable iff (mreset)
    shift_clk |-> (active_q && hc_q >= HW'(D0) && hc_q < HW'(D1) && !hc_q[0])); // R6
  AST_MID_FLIP: assert property (@(posedge enc_clk) disable iff (mreset)
    (active_q && hc_q[0] && hc_q >= HW'(D0)) |-> (pos_q != $past(pos_q))); // R5
  AST_SYNC_HOLD: assert property (@(posedge enc_clk) disable iff (mreset)
    (active_q && hc_q != '0 && hc_q < HW'(D0) && hc_q != HW'(SYNC_HALVES))
      |-> $stable(pos_q)); // R4
  AST_SYNC_FLIP: assert property (@(posedge enc_clk) disable iff (mreset)
    (active_q && hc_q == HW'(SYNC_HALVES)) |-> (pos_q != $past(pos_q))); // R4
  AST_HC_STEP: assert property (@(posedge enc_clk) disable iff (mreset)
    (active_q && hc_q != HW'(HALVES - 1)) |=> (active_q && hc_q == $past(hc_q) + HW'(1))); // R3
  AST_DIV_HOLD: assert property (@(posedge enc_clk) disable iff (mreset)
    $rose(div6_clk) |=> $stable(div6_clk)); // R2
endmodule

bind manch_word_enc manch_word_enc_chk #(
  .DATA_BITS(DATA_BITS), .SYNC_HALVES(SYNC_HALVES), .HW(HW)
) u_chk (
  .enc_clk(enc_clk), .mreset(mreset), .line_inhibit_n(line_inhibit_n),
  .shift_clk(shift_clk), .pos_n(pos_n), .neg_n(neg_n), .div6_clk(div6_clk),
  .active_q(active_q), .hc_q(hc_q), .pos_q(pos_q)
);

// File: tb/manch_word_enc_bench.sv
module manch_word_enc_bench;
  localparam int N  = 16;
  localparam int SH = 3;
  localparam int HT = 2 * SH + 2 * N + 2;
  localparam int NF = 40;

  logic enc_clk = 1'b0, mreset = 1'b1, sync_sel = 1'b0, enc_en = 1'b0;
  logic ser_in = 1'b0, line_inhibit_n = 1'b1;
  logic shift_clk, pos_n, neg_n, div6_clk;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  manch_word_enc u_manch_word_enc (
    .enc_clk(enc_clk), .mreset(mreset), .sync_sel(sync_sel), .enc_en(enc_en),
    .ser_in(ser_in), .line_inhibit_n(line_inhibit_n), .shift_clk(shift_clk),
    .pos_n(pos_n), .neg_n(neg_n), .div6_clk(div6_clk)
  );

  always #5 enc_clk = ~enc_clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] word_of(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'hAAAA;
      3: return 16'h5555;
      default:
        if (i < 4 + N) return 16'(1) << (i - 4);
        else if (i < 4 + N + 4) return ~(16'(1) << (3 * (i - 4 - N)));
        else return 16'((i * 40503 + 12345) ^ (i << 9));
    endcase
  endfunction

  // Expected line level (1 = positive) at half-cell h.
  function automatic bit exp_pos(input int h, input logic [N-1:0] w, input bit cmd);
    int k; bit b;
    if (h < 2 * SH) return cmd ? (h < SH) : (h >= SH);
    if (h < 2 * SH + 2 * N) begin
      k = (h - 2 * SH) / 2;
      b = w[N - 1 - k];
      return (h % 2 == 0) ? b : !b;
    end
    b = ($countones(w) % 2 == 0);
    return (h % 2 == 0) ? b : !b;
  endfunction

  // Called at a negedge; the next posedge loads half-cell 0.
  task automatic run_frame(input logic [N-1:0] w, input bit cmd, input bit chained,
                           input bit next_en, input bit next_cmd, input int inh_h);
    bit e, sh; int nh; string tag;
    for (int h = 0; h < HT; h++) begin
      @(negedge enc_clk);
      if (h == inh_h) begin
        line_inhibit_n = 1'b0;
        #1;
        chk("R9", "inhibited pos_n", int'(pos_n), 1);
        chk("R9", "inhibited neg_n", int'(neg_n), 1);
        line_inhibit_n = 1'b1;
        #1;
      end
      e   = exp_pos(h, w, cmd);
      sh  = (h >= 2 * SH) && (h < 2 * SH + 2 * N) && (h % 2 == 0);
      tag = (h == 0) ? (chained ? "R10" : "R3") :
            (h < 2 * SH) ? "R4" : (h < 2 * SH + 2 * N) ? "R5" : "R7";
      chk(tag, "pos_n", int'(pos_n), int'(!e));
      chk("R8", "neg_n", int'(neg_n), int'(e));
      chk("R6", "shift_clk", int'(shift_clk), int'(sh));
      nh = h + 1;
      if (h == HT - 1) begin
        enc_en = next_en; sync_sel = next_cmd; ser_in = 1'($urandom() % 2);
      end else begin
        enc_en   = 1'($urandom() % 2);
        sync_sel = 1'($urandom() % 2);
        if (nh >= 2 * SH && nh < 2 * SH + 2 * N && nh % 2 == 0)
          ser_in = w[N - 1 - (nh - 2 * SH) / 2];
        else
          ser_in = 1'($urandom() % 2);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge enc_clk);
    chk("R1", "reset pos_n", int'(pos_n), 1);
    chk("R1", "reset neg_n", int'(neg_n), 1);
    chk("R1", "reset shift_clk", int'(shift_clk), 0);
    chk("R1", "reset div6_clk", int'(div6_clk), 0);
    mreset = 1'b0;
    for (int e = 1; e <= 18; e++) begin
      @(negedge enc_clk);
      chk("R2", "div6_clk", int'(div6_clk), (e / 3) % 2);
      chk("R3", "idle pos_n", int'(pos_n), 1);
      chk("R3", "idle neg_n", int'(neg_n), 1);
    end

    enc_en = 1'b1; sync_sel = 1'b1;
    for (int i = 0; i < NF; i++) begin
      bit cmd, nxt, ncmd, chained;
      cmd     = (i % 2 == 0);
      ncmd    = ((i + 1) % 2 == 0);
      nxt     = (i % 4 != 3) && (i < NF - 1);
      chained = (i % 4 != 0);
      run_frame(word_of(i), cmd, chained, nxt, ncmd, (i * 7) % HT);
      if (!nxt) begin
        for (int g = 0; g < 3; g++) begin
          @(negedge enc_clk);
          chk("R3", "gap pos_n", int'(pos_n), 1);
          chk("R3", "gap neg_n", int'(neg_n), 1);
          chk("R6", "gap shift_clk", int'(shift_clk), 0);
          ser_in = 1'($urandom() % 2);
        end
        enc_en = 1'b1; sync_sel = ncmd;
      end
    end
    enc_en = 1'b0;

    // Reset in the middle of a frame.
    @(negedge enc_clk);
    enc_en = 1'b1; sync_sel = 1'b1;
    @(negedge enc_clk);
    enc_en = 1'b0;
    repeat (10) @(negedge enc_clk);
    mreset = 1'b1;
    #1;
    chk("R1", "mid-frame reset pos_n", int'(pos_n), 1);
    chk("R1", "mid-frame reset neg_n", int'(neg_n), 1);
    chk("R1", "mid-frame reset div6_clk", int'(div6_clk), 0);
    @(negedge enc_clk);
    mreset = 1'b0;
    enc_en = 1'b1; sync_sel = 1'b0;
    run_frame(16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    @(negedge enc_clk);
    chk("R3", "final idle pos_n", int'(pos_n), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule